// File: doc/BRIEF.md
# Boot Fetch Lock Controller

This block decides where the processor may fetch instructions after reset. Until the next-stage boot image has been proven authentic, only addresses inside a fixed on-chip boot ROM window are served. A request for any other address is refused and flagged with a fault, so code in external flash cannot run early. The hash and signature work happens outside the block, behind a simple request/done/pass handshake.

Out of reset the block raises its verify request and waits for a verdict. A passing verdict opens the fetch lock for good and captures the image entry address. One cycle later the block issues a single-cycle program-counter redirect that carries that address. A failing verdict keeps the lock shut and raises a sticky boot-failure flag. Only one verdict is taken per reset. Nothing but a reset can shut the lock again.

Top module: `boot_fetch_guard`

## Requirements
- R1: While reset is held and right after it is released, `fetch_open` is 0, `boot_fail` is 0 and `pc_jump_valid` is 0. After release, `vrf_req` is 1.
- R2: A requested fetch whose address lies in the window [ROM_BASE, ROM_BASE+ROM_SIZE) is granted in the same cycle and raises no fault, whatever the lock state.
- R3: While `fetch_open` is 0, a requested fetch outside the ROM window is not granted, and `fetch_fault` is high for that same cycle.
- R4: A cycle with `vrf_done`=1 and `vrf_pass`=1 while the verify request is pending sets `fetch_open` at the next clock edge and drops `vrf_req`.
- R5: While `fetch_open` is 1, every requested fetch is granted and `fetch_fault` stays 0.
- R6: `pc_jump_valid` is high for exactly one cycle, the cycle after `fetch_open` rises. During that cycle `pc_jump_addr` equals the `entry_addr` value sampled together with the passing verdict.
- R7: A cycle with `vrf_done`=1 and `vrf_pass`=0 while the verify request is pending sets `boot_fail` at the next edge and drops `vrf_req`. `boot_fail` then stays 1 and `fetch_open` stays 0 until reset, even if a later passing verdict arrives.
- R8: Once `fetch_open` is 1, it stays 1 until reset. Later verdicts of either kind produce no further redirect and leave `boot_fail` at 0.
- R9: `vrf_pass` has no effect in a cycle where `vrf_done` is 0.
- R10: With `fetch_req` at 0, both `fetch_gnt` and `fetch_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | AW | Fetch address |
| fetch_gnt | output | 1 | Fetch granted this cycle |
| fetch_fault | output | 1 | Fetch refused by the lock this cycle |
| vrf_req | output | 1 | Verification of the next-stage image requested |
| vrf_done | input | 1 | Verdict valid this cycle |
| vrf_pass | input | 1 | Verdict: signature valid |
| entry_addr | input | AW | Entry point of the verified image |
| fetch_open | output | 1 | Lock state: 1 means fetches from any address are allowed |
| boot_fail | output | 1 | Sticky verification-failure flag |
| pc_jump_valid | output | 1 | One-cycle program-counter redirect strobe |
| pc_jump_addr | output | AW | Redirect target address |

## Verification
A corrupted lock or sequencer state shows up at once in the fetch path. An outside-window request is then either granted while still locked or faulted after unlock, in the same cycle it is made. A sequencer that loses track of the verdict shows up as a missing, doubled or misplaced redirect strobe, one or two cycles after the verdict. It can also show up as a verify request that never drops. A lost failure flag shows up on `boot_fail` on the edge after a failing verdict.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic [1:0] {
    ST_VERIFY = 2'd0,
    ST_JUMP   = 2'd1,
    ST_RUN    = 2'd2,
    ST_FAIL   = 2'd3
  } boot_state_t;
endpackage

// File: rtl/boot_rom_window.sv
module boot_rom_window #(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] ROM_BASE = '0,
  parameter logic [AW-1:0] ROM_SIZE = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  // one extra bit keeps the window end from wrapping
  localparam logic [AW:0] ROM_END = {1'b0, ROM_BASE} + {1'b0, ROM_SIZE};

  always_comb begin
    hit = ({1'b0, addr} >= {1'b0, ROM_BASE}) && ({1'b0, addr} < ROM_END);
  end
endmodule

// File: rtl/boot_fetch_gate.sv
module boot_fetch_gate (
  input  logic req,
  input  logic in_rom,
  input  logic open,
  output logic gnt,
  output logic fault
);
  always_comb begin
    gnt   = req & (in_rom | open);
    fault = req & ~in_rom & ~open;
  end
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_guard_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vrf_done,
  input  logic          vrf_pass,
  input  logic [AW-1:0] entry_addr,
  output logic          vrf_req,
  output logic          open,
  output logic          fail,
  output logic          jump_valid,
  output logic [AW-1:0] jump_addr
);
  boot_state_t   state_q, state_n;
  logic          open_q, fail_q, jump_q;
  logic [AW-1:0] entry_q;
  logic          verdict, pass_set, fail_set;

  // next-state logic
  always_comb begin
    verdict  = (state_q == ST_VERIFY) & vrf_done;
    pass_set = verdict & vrf_pass;
    fail_set = verdict & ~vrf_pass;
    state_n  = state_q;
    unique case (state_q)
      ST_VERIFY: if (vrf_done) state_n = vrf_pass ? ST_JUMP : ST_FAIL;
      ST_JUMP:   state_n = ST_RUN;
      ST_RUN:    state_n = ST_RUN;
      ST_FAIL:   state_n = ST_FAIL;
      default:   state_n = ST_FAIL;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_VERIFY;
      open_q  <= 1'b0;
      fail_q  <= 1'b0;
      jump_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      state_q <= state_n;
      jump_q  <= (state_q == ST_JUMP);
      if (pass_set) open_q  <= 1'b1;
      if (fail_set) fail_q  <= 1'b1;
      if (pass_set) entry_q <= entry_addr;
    end
  end

  always_comb begin
    vrf_req    = (state_q == ST_VERIFY);
    open       = open_q;
    fail       = fail_q;
    jump_valid = jump_q;
    jump_addr  = entry_q;
  end
endmodule

// File: rtl/boot_fetch_guard.sv
module boot_fetch_guard #(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] ROM_BASE = 32'h0000_1000,
  parameter logic [AW-1:0] ROM_SIZE = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_gnt,
  output logic          fetch_fault,
  output logic          vrf_req,
  input  logic          vrf_done,
  input  logic          vrf_pass,
  input  logic [AW-1:0] entry_addr,
  output logic          fetch_open,
  output logic          boot_fail,
  output logic          pc_jump_valid,
  output logic [AW-1:0] pc_jump_addr
);
  logic rom_hit;

  boot_rom_window #(.AW(AW), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)) u_win (
    .addr (fetch_addr),
    .hit  (rom_hit)
  );

  boot_seq_ctrl #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .vrf_done   (vrf_done),
    .vrf_pass   (vrf_pass),
    .entry_addr (entry_addr),
    .vrf_req    (vrf_req),
    .open       (fetch_open),
    .fail       (boot_fail),
    .jump_valid (pc_jump_valid),
    .jump_addr  (pc_jump_addr)
  );

  boot_fetch_gate u_gate (
    .req    (fetch_req),
    .in_rom (rom_hit),
    .open   (fetch_open),
    .gnt    (fetch_gnt),
    .fault  (fetch_fault)
  );
endmodule

// File: rtl/boot_fetch_guard_chk.sv
module boot_fetch_guard_chk #(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] ROM_BASE = '0,
  parameter logic [AW-1:0] ROM_SIZE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_gnt,
  input logic          fetch_fault,
  input logic          vrf_req,
  input logic          vrf_done,
  input logic          vrf_pass,
  input logic          fetch_open,
  input logic          boot_fail,
  input logic          pc_jump_valid
);
  logic in_win;
  always_comb begin
    in_win = ({1'b0, fetch_addr} >= {1'b0, ROM_BASE}) &&
             ({1'b0, fetch_addr} < ({1'b0, ROM_BASE} + {1'b0, ROM_SIZE}));
  end

  assert_rom_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && in_win) |-> (fetch_gnt && !fetch_fault));

  assert_locked_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !in_win && !fetch_open) |-> (!fetch_gnt && fetch_fault));

  assert_unlock_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_open) |-> $past(vrf_done && vrf_pass && vrf_req));

  assert_open_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_open) |-> (fetch_gnt && !fetch_fault));

  assert_jump_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_open) |=> pc_jump_valid);

  assert_jump_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_jump_valid |=> !pc_jump_valid);

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |=> (boot_fail && !fetch_open));

  assert_open_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_open |=> (fetch_open && !boot_fail));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> (!fetch_gnt && !fetch_fault));
endmodule

bind boot_fetch_guard boot_fetch_guard_chk #(
  .AW(AW), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_req     (fetch_req),
  .fetch_addr    (fetch_addr),
  .fetch_gnt     (fetch_gnt),
  .fetch_fault   (fetch_fault),
  .vrf_req       (vrf_req),
  .vrf_done      (vrf_done),
  .vrf_pass      (vrf_pass),
  .fetch_open    (fetch_open),
  .boot_fail     (boot_fail),
  .pc_jump_valid (pc_jump_valid)
);

// File: tb/tb_boot_fetch_guard.sv
module tb_boot_fetch_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [AW-1:0] ROM_BASE = 32'h0000_1000;
  localparam logic [AW-1:0] ROM_SIZE = 32'h0000_1000;

  logic          clk;
  logic          rst_n;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          fetch_gnt, fetch_fault, vrf_req;
  logic          vrf_done, vrf_pass;
  logic [AW-1:0] entry_addr;
  logic          fetch_open, boot_fail, pc_jump_valid;
  logic [AW-1:0] pc_jump_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [AW-1:0] exp_jump_q[$];

  boot_fetch_guard #(.AW(AW), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_gnt(fetch_gnt), .fetch_fault(fetch_fault),
    .vrf_req(vrf_req), .vrf_done(vrf_done), .vrf_pass(vrf_pass),
    .entry_addr(entry_addr),
    .fetch_open(fetch_open), .boot_fail(boot_fail),
    .pc_jump_valid(pc_jump_valid), .pc_jump_addr(pc_jump_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // main process works at posedge+2; monitor at negedge, so counters never collide
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic fetch_probe(input string req, input logic [AW-1:0] a,
                             input logic eg, input logic ef);
    fetch_req  = 1'b1;
    fetch_addr = a;
    #1;
    chk({req, " gnt"},   {31'd0, fetch_gnt},   {31'd0, eg});
    chk({req, " fault"}, {31'd0, fetch_fault}, {31'd0, ef});
    fetch_req = 1'b0;
  endtask

  // driver: one verdict cycle; a pass pushes the expected redirect target
  task automatic verdict(input logic pass, input logic [AW-1:0] entry, input logic expect_jump);
    vrf_done   = 1'b1;
    vrf_pass   = pass;
    entry_addr = entry;
    if (expect_jump) exp_jump_q.push_back(entry);
    step();
    vrf_done = 1'b0;
    vrf_pass = 1'b0;
  endtask

  // monitor: every redirect strobe must match the next expected entry
  always @(negedge clk) begin
    if (rst_n && pc_jump_valid) begin
      if (exp_jump_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R6/R8: actual redirect to %h expected none", pc_jump_addr);
      end else begin
        chk("R6 redirect target", pc_jump_addr, exp_jump_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 open in reset", {31'd0, fetch_open},    32'd0);
    chk("R1 fail in reset", {31'd0, boot_fail},     32'd0);
    chk("R1 jump in reset", {31'd0, pc_jump_valid}, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 vrf_req after reset", {31'd0, vrf_req},    32'd1);
    chk("R1 open after reset",    {31'd0, fetch_open}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0;
    vrf_done = 1'b0; vrf_pass = 1'b0; entry_addr = '0;
    do_reset();

    // locked fetch behaviour
    fetch_probe("R2 rom base", ROM_BASE, 1'b1, 1'b0);
    fetch_probe("R2 rom last", ROM_BASE + ROM_SIZE - 1, 1'b1, 1'b0);
    fetch_probe("R3 below rom", ROM_BASE - 4, 1'b0, 1'b1);
    fetch_probe("R3 rom end", ROM_BASE + ROM_SIZE, 1'b0, 1'b1);
    fetch_probe("R3 flash", 32'h8000_0000, 1'b0, 1'b1);
    fetch_req = 1'b0; fetch_addr = 32'h8000_0000; #1;
    chk("R10 no req gnt",   {31'd0, fetch_gnt},   32'd0);
    chk("R10 no req fault", {31'd0, fetch_fault}, 32'd0);

    // pass without done
    vrf_pass = 1'b1; entry_addr = 32'hDEAD_0000;
    step(); step();
    vrf_pass = 1'b0;
    chk("R9 pass alone open",  {31'd0, fetch_open}, 32'd0);
    chk("R9 pass alone req",   {31'd0, vrf_req},    32'd1);

    // passing verdict
    verdict(1'b1, 32'h8000_0100, 1'b1);
    chk("R4 open after pass",  {31'd0, fetch_open},    32'd1);
    chk("R4 vrf_req dropped",  {31'd0, vrf_req},       32'd0);
    chk("R6 no jump yet",      {31'd0, pc_jump_valid}, 32'd0);
    step();
    chk("R6 jump strobe",      {31'd0, pc_jump_valid}, 32'd1);
    chk("R6 jump addr",        pc_jump_addr, 32'h8000_0100);
    step();
    chk("R6 jump one cycle",   {31'd0, pc_jump_valid}, 32'd0);
    fetch_probe("R5 flash open", 32'h8000_0100, 1'b1, 1'b0);
    fetch_probe("R5 rom open", ROM_BASE, 1'b1, 1'b0);

    // later verdicts ignored
    verdict(1'b0, 32'h9000_0000, 1'b0);
    verdict(1'b1, 32'hA000_0000, 1'b0);
    step(); step();
    chk("R8 still open",  {31'd0, fetch_open}, 32'd1);
    chk("R8 no fail",     {31'd0, boot_fail},  32'd0);

    // failing path
    do_reset();
    verdict(1'b0, 32'h8000_0200, 1'b0);
    chk("R7 fail set",      {31'd0, boot_fail},  32'd1);
    chk("R7 still locked",  {31'd0, fetch_open}, 32'd0);
    chk("R7 vrf_req drop",  {31'd0, vrf_req},    32'd0);
    verdict(1'b1, 32'h8000_0300, 1'b0);
    step(); step();
    chk("R7 late pass locked", {31'd0, fetch_open}, 32'd0);
    chk("R7 fail sticky",      {31'd0, boot_fail},  32'd1);
    fetch_probe("R7 flash refused", 32'h8000_0300, 1'b0, 1'b1);
    fetch_probe("R2 rom after fail", ROM_BASE + 32'h10, 1'b1, 1'b0);

    chk("R6 all redirects seen", exp_jump_q.size(), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule